// File: doc/BRIEF.md
# Serial Frame Aligner with 1:16 Word Assembly

This block sits on the receive side of a SONET/SDH link, after clock recovery. It takes one serial bit per cycle in which a bit-rate enable is high and assembles every sixteen accepted bits into a parallel word, first bit in the most significant position. When told to hunt, it slides a 32-bit window over the stream. The window is checked at every bit position. When the two-A1, two-A2 framing sequence appears, the block moves its word boundary to the bit that follows the sequence and marks the first word built on the new boundary with a frame pulse.

Hunting starts only on a rising edge of the out-of-frame input, and only while frame-enable is high. Once the pattern is found, hunting stops and the boundary stays where it is. Further framing patterns are then ignored until the next out-of-frame edge. If frame-enable is pulled low, any search in progress is abandoned and the current boundary is kept. Recovering the clock, monitoring overhead other than the framing bytes, and descrambling are handled elsewhere.

Top module: `frame_deser`

## Requirements
- R1: Output words are built most significant bit first. The first accepted bit after a word boundary lands in bit 15. The word appears on `word_out`, with `word_valid` high for one clock, in the clock after the sixteenth bit is accepted.
- R2: `bit_in` is sampled only in cycles where `bit_en` is high. Its value in any other cycle has no effect on the words produced.
- R3: A search begins only on a rising edge of `oof` seen while `frame_en` is high. If `frame_en` rises while `oof` is already high, no search starts.
- R4: While searching, the 32-bit sequence 0xF6F62828 (A1 = 0xF6 twice, then A2 = 0x28 twice, first bit is bit 31) is recognised at any bit offset. The next output word starts with the bit that follows the last pattern bit.
- R5: `frame_pulse` is high for exactly one clock, together with `word_valid`, on the first word completed after a detection, and at no other time.
- R6: After a detection the search ends. A later framing pattern at a different offset neither moves the boundary nor raises `frame_pulse` until the next qualifying `oof` edge.
- R7: Driving `frame_en` low cancels a search and keeps the current word boundary. Raising `frame_en` again does not resume the search without a new `oof` edge.
- R8: While `rst_n` is low, all outputs are zero and no `word_valid` strobes appear. After reset, the first word boundary falls sixteen accepted bits after release.
- R9: A 32-bit window that differs from the framing sequence in any single bit does not lock the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | High in cycles where `bit_in` carries a valid bit |
| bit_in | input | 1 | Serial data |
| frame_en | input | 1 | Permits frame search; low cancels it |
| oof | input | 1 | Out-of-frame indication; rising edge starts a search |
| word_out | output | 16 | Assembled parallel word, MSB is the earliest bit |
| word_valid | output | 1 | One-clock strobe for a new `word_out` |
| frame_pulse | output | 1 | Marks the first word aligned after a detection |

## Verification
A wrong bit counter shows up in the next strobed word, which comes out rotated against the bench's known boundary within sixteen accepted bits. A search flag stuck high shows up as a frame pulse and a relocated boundary the first time a framing pattern is sent at a new offset. A search flag that never rises shows up as a missing pulse one word after the pattern. Each scenario therefore ends with one payload word sent on a known boundary. That word is compared with what the bench expects, and the number of frame pulses seen is checked.

// File: rtl/frame_deser.sv
module frame_deser #(
  parameter int WORD_W = 16,
  parameter int PAT_W  = 32,
  parameter logic [PAT_W-1:0] PATTERN = 32'hF6F62828
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              frame_en,
  input  logic              oof,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              frame_pulse
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int SR_W  = (PAT_W > WORD_W) ? PAT_W : WORD_W;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic [SR_W-1:0]  sr;
  logic [SR_W-1:0]  sr_nxt;
  logic [CNT_W-1:0] cnt;
  logic             oof_q;
  logic             hunt;
  logic             fp_pend;
  logic             hit;
  logic             last;
  logic             oof_rise;

  assign sr_nxt   = {sr[SR_W-2:0], bit_in};
  assign hit      = hunt && frame_en && bit_en && (sr_nxt[PAT_W-1:0] == PATTERN);
  assign last     = bit_en && (cnt == LAST_POS);
  assign oof_rise = oof && !oof_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr          <= '0;
      cnt         <= '0;
      oof_q       <= 1'b0;
      hunt        <= 1'b0;
      fp_pend     <= 1'b0;
      word_out    <= '0;
      word_valid  <= 1'b0;
      frame_pulse <= 1'b0;
    end else begin
      oof_q       <= oof;
      word_valid  <= 1'b0;
      frame_pulse <= 1'b0;
      if (bit_en) sr <= sr_nxt;

      if (!frame_en || hit) hunt <= 1'b0;
      else if (oof_rise)    hunt <= 1'b1;

      if (hit) begin
        cnt     <= '0;
        fp_pend <= 1'b1;
      end else if (bit_en) begin
        cnt <= last ? '0 : cnt + 1'b1;
        if (last) begin
          word_out    <= sr_nxt[WORD_W-1:0];
          word_valid  <= 1'b1;
          frame_pulse <= fp_pend;
          fp_pend     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/frame_deser_chk.sv
module frame_deser_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic frame_en,
  input logic oof,
  input logic word_valid,
  input logic frame_pulse,
  input logic hunt
);
  assert_no_strobe_in_reset_R8: assert property (@(posedge clk) disable iff (rst_n)
    !word_valid && !frame_pulse);

  assert_pulse_with_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> word_valid);

  assert_word_after_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_en));

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_search_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hunt) |-> ($past(oof) && $past(frame_en)));

  assert_disable_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> !hunt);
endmodule

bind frame_deser frame_deser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_en(frame_en), .oof(oof),
  .word_valid(word_valid), .frame_pulse(frame_pulse), .hunt(hunt)
);

// File: tb/sim_frame_deser.sv
module sim_frame_deser;
  localparam logic [31:0] FRAME = 32'hF6F62828;
  localparam int NVEC = 4;
  localparam logic [20:0] VEC [NVEC] = '{
    {5'd0,  16'hA55A},
    {5'd7,  16'h8001},
    {5'd13, 16'h1234},
    {5'd1,  16'hFFFE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, bit_in = 1'b0, frame_en = 1'b0, oof = 1'b0;
  logic [15:0] word_out;
  logic word_valid, frame_pulse;

  int total = 0, fails = 0;
  int vcnt = 0, fpcnt = 0;
  logic [15:0] last_word = '0, fp_word = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_deser u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .frame_en(frame_en), .oof(oof),
    .word_out(word_out), .word_valid(word_valid), .frame_pulse(frame_pulse)
  );

  always @(negedge clk) if (word_valid) begin
    vcnt++;
    last_word = word_out;
    if (frame_pulse) begin fpcnt++; fp_word = word_out; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0; bit_in = ~b;
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_vec(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic oof_pulse();
    @(negedge clk); oof = 1'b1;
    repeat (2) @(negedge clk); oof = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int fp0;
    // R8: no strobes while reset is held, even with bits offered
    send_vec(32'h0000FFFF, 32);
    @(negedge clk);
    chk(vcnt == 0 && word_out == 0 && frame_pulse == 0, "R8 reset quiet", vcnt, 0);
    rst_n = 1'b1;
    frame_en = 1'b1;
    // R8/R1/R2: first boundary 16 bits after release, MSB first, noise between enables
    send_vec(32'h0000C3C3, 16); settle();
    chk(last_word == 16'hC3C3 && vcnt == 1, "R8 R1 first word", last_word, 16'hC3C3);
    chk(fpcnt == 0, "R5 no pulse before search", fpcnt, 0);

    // table: search, offset, pattern, payload; then a second word on the held boundary
    for (int k = 0; k < NVEC; k++) begin
      fp0 = fpcnt;
      oof_pulse();
      send_zeros(int'(VEC[k][20:16]));
      send_vec(FRAME, 32);
      send_vec({16'h0, VEC[k][15:0]}, 16); settle();
      chk(fpcnt == fp0 + 1 && fp_word == VEC[k][15:0], "R4 R5 lock word", fp_word, VEC[k][15:0]);
      send_vec({16'h0, ~VEC[k][15:0]}, 16); settle();
      chk(last_word == ~VEC[k][15:0] && fpcnt == fp0 + 1, "R5 R6 next word", last_word, ~VEC[k][15:0]);
    end

    // R6: a pattern at a new offset after lock is ignored
    fp0 = fpcnt;
    send_zeros(5); send_vec(FRAME, 32); send_zeros(11);
    send_vec(32'h00005A3C, 16); settle();
    chk(last_word == 16'h5A3C && fpcnt == fp0, "R6 no relock", last_word, 16'h5A3C);

    // R3: frame_en low during oof edge, raised while oof still high
    fp0 = fpcnt;
    frame_en = 1'b0;
    @(negedge clk); oof = 1'b1;
    repeat (2) @(negedge clk); frame_en = 1'b1;
    send_zeros(3); send_vec(FRAME, 32); send_zeros(13);
    send_vec(32'h00006E21, 16); settle();
    oof = 1'b0;
    chk(last_word == 16'h6E21 && fpcnt == fp0, "R3 no search without edge", last_word, 16'h6E21);

    // R7: search cancelled by frame_en low, not resumed on re-enable
    fp0 = fpcnt;
    oof_pulse();
    frame_en = 1'b0;
    repeat (3) @(negedge clk);
    frame_en = 1'b1;
    send_zeros(3); send_vec(FRAME, 32); send_zeros(13);
    send_vec(32'h0000B00B, 16); settle();
    chk(last_word == 16'hB00B && fpcnt == fp0, "R7 cancelled search", last_word, 16'hB00B);

    // R7: frame_en held low, boundary kept through a pattern
    frame_en = 1'b0;
    oof_pulse();
    send_zeros(9); send_vec(FRAME, 32); send_zeros(7);
    send_vec(32'h00007711, 16); settle();
    chk(last_word == 16'h7711 && fpcnt == fp0, "R7 disabled keeps boundary", last_word, 16'h7711);
    frame_en = 1'b1;

    // R9: one-bit-off pattern does not lock; the true one then does
    fp0 = fpcnt;
    oof_pulse();
    send_zeros(3); send_vec(FRAME ^ 32'h00010000, 32); settle();
    chk(fpcnt == fp0, "R9 near miss ignored", fpcnt, fp0);
    send_zeros(2); send_vec(FRAME, 32);
    send_vec(32'h00004C4D, 16); settle();
    chk(fpcnt == fp0 + 1 && fp_word == 16'h4C4D, "R9 R4 lock after miss", fp_word, 16'h4C4D);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule